// File: doc/BRIEF.md
# I2S audio serial port

This block is a register-mapped serial audio port for 16-bit stereo. Software writes a left and a right transmit sample, a bit-clock divider and a mode word over a word-wide register bus. When the internal clock source is selected, the port produces its own bit clock and word select from the system clock. It shifts transmit data out most significant bit first, in the usual I2S layout. At the same time it shifts data in from the serial input and latches each complete word into a left or a right receive register.

The transmit words are double-buffered. A write from software lands in a holding register, and that register is copied into the shifter only when its channel slot begins. A single-cycle interrupt, selected by mode bits, marks word-select edges. Software uses it to pace sample refill. When the external clock source is selected, the bit clock and word select come in from pins through synchronizers, and the divider has no effect.

Top module: `i2s_port`

## Requirements
- R1: After reset the divider holds 19, the mode register holds 0 (external clock), both receive registers read 0, and `irq`, `irq_pending`, `sck_out`, `ws_out` and `sd_out` are low.
- R2: With mode bit 0 set, `sck_out` has a period of 2·(N+1) system clocks, where N is the 8-bit value written at offset 0x8. A new N takes effect without a reset.
- R3: A frame is 32 bit clocks. `ws_out` is low for 16 rising edges of `sck_out` (left slot) and high for 16 (right slot). It changes only in the cycle in which `sck_out` falls, except when a mode write occurs.
- R4: `sd_out` changes only as `sck_out` falls. Each word starts one bit clock after the word-select transition, most significant bit first. The left word goes out while `ws_out` is low and the right word while it is high.
- R5: Transmit writes (offset 0x0 left, 0x4 right, data in bits 15:0) go to holding registers. A word already being shifted completes unchanged, and the new value goes out in the next slot of that channel.
- R6: `sd_in` is sampled on each rising bit-clock edge. After the 16th bit of a word, that word is latched into the receive register of its channel. Reads at 0x0 return left receive data and reads at 0x4 return right receive data.
- R7: Reads at any offset other than 0x0 and 0x4 return 0xFFFF.
- R8: When mode bit 2 (word-strobe enable) is clear, `ws_out` stays low while `sck_out` keeps running.
- R9: Mode bit 3 makes `irq` pulse on each rising word-select edge, bit 4 on each falling edge, and bit 5 on both. Each pulse lasts one cycle and is never stretched to two.
- R10: With mode bits 3 to 5 clear, `irq` never pulses, and the port keeps sending the last held words frame after frame.
- R11: Every `irq` pulse sets `irq_pending`. A write to the mode register at offset 0xC clears it, unless a pulse occurs in the same cycle.
- R12: With mode bit 0 clear, `sck_in` and `ws_in` pass through a two-flop synchronizer, and receive framing follows them. The divider is ignored and `sck_out` and `ws_out` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register; bits 3:2 select it |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| sck_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word select |
| sd_in | input | 1 | Serial receive data |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word select |
| sd_out | output | 1 | Serial transmit data |
| irq | output | 1 | Single-cycle frame interrupt |
| irq_pending | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach from the ports is a transmit write that lands while a word is in the middle of its shift. The stimulus watches the decoded serial stream and issues the write after the fifth bit of a left word. It then expects the old word to complete and the new word to appear in the next left slot. Clearing the pending flag has a similar problem: a mode write that coincides with a word-select edge would set the flag again. So the bench issues that write mid-slot, away from any edge. Externally clocked framing is driven bit by bit from the bench across several frames, so that the synchronized word select realigns the bit position.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

  // Mode register layout: bit 0 is clk_int, bit 5 is every_word.
  typedef struct packed {
    logic every_word;
    logic irq_on_fall;
    logic irq_on_rise;
    logic strobe_en;
    logic alt_sel;
    logic clk_int;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);

  // Register slot picked by address bits 3:2.
  typedef enum logic [1:0] {
    SLOT_LEFT  = 2'd0,
    SLOT_RIGHT = 2'd1,
    SLOT_DIV   = 2'd2,
    SLOT_MODE  = 2'd3
  } reg_slot_e;

endpackage

// File: rtl/i2s_port_regs.sv
module i2s_port_regs
  import i2s_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DIV_RST = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_left,
  input  logic [DATA_W-1:0] rx_right,
  output logic [DATA_W-1:0] tx_left,
  output logic [DATA_W-1:0] tx_right,
  output logic [DIV_W-1:0]  div_n,
  output mode_t             mode,
  output logic              mode_wr
);

  localparam int unsigned SLOT_LSB = 2;

  reg_slot_e         slot;
  logic [DATA_W-1:0] tx_l_q, tx_l_d, tx_r_q, tx_r_d;
  logic [DIV_W-1:0]  div_q, div_d;
  mode_t             mode_q, mode_d;
  logic              unused_bits;

  assign slot        = reg_slot_e'(bus_addr[SLOT_LSB+1:SLOT_LSB]);
  assign unused_bits = ^{bus_addr[SLOT_LSB-1:0], mode_q.alt_sel};

  always_comb begin
    tx_l_d  = tx_l_q;
    tx_r_d  = tx_r_q;
    div_d   = div_q;
    mode_d  = mode_q;
    mode_wr = 1'b0;
    if (bus_wen) begin
      unique case (slot)
        SLOT_LEFT:  tx_l_d = bus_wdata;
        SLOT_RIGHT: tx_r_d = bus_wdata;
        SLOT_DIV:   div_d  = bus_wdata[DIV_W-1:0];
        SLOT_MODE: begin
          mode_d  = mode_t'(bus_wdata[MODE_W-1:0]);
          mode_wr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_LEFT:  bus_rdata = rx_left;
      SLOT_RIGHT: bus_rdata = rx_right;
      default:    bus_rdata = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_l_q <= '0;
      tx_r_q <= '0;
      div_q  <= DIV_W'(DIV_RST);
      mode_q <= '0;
    end else if (bus_wen) begin
      tx_l_q <= tx_l_d;
      tx_r_q <= tx_r_d;
      div_q  <= div_d;
      mode_q <= mode_d;
    end
  end

  assign tx_left  = tx_l_q;
  assign tx_right = tx_r_q;
  assign div_n    = div_q;
  assign mode     = mode_q;

endmodule

// File: rtl/i2s_port_clkgen.sv
module i2s_port_clkgen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_int,
  input  logic [DIV_W-1:0] div_n,
  input  logic             sck_ext,
  input  logic             ws_ext,
  output logic             sck_int,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             ws_ext_s
);

  localparam int unsigned SMSB = SYNC_STAGES - 1;

  logic [DIV_W-1:0]       cnt_q, cnt_d;
  logic                   sck_q, sck_d;
  logic                   tick;
  logic [SYNC_STAGES-1:0] sck_sync_q, ws_sync_q;
  logic                   sck_last_q;
  logic                   ext_rise, ext_fall;

  // Divider: the level toggles every N+1 clocks, so a full period is 2(N+1).
  always_comb begin
    tick  = clk_int && (cnt_q >= div_n);
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!clk_int) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  // Synchronizers for the externally supplied clock and word select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync_q <= '0;
      ws_sync_q  <= '0;
      sck_last_q <= 1'b0;
    end else begin
      sck_sync_q <= {sck_sync_q[SMSB-1:0], sck_ext};
      ws_sync_q  <= {ws_sync_q[SMSB-1:0], ws_ext};
      sck_last_q <= sck_sync_q[SMSB];
    end
  end

  assign ext_rise = sck_sync_q[SMSB] & ~sck_last_q;
  assign ext_fall = ~sck_sync_q[SMSB] & sck_last_q;

  always_comb begin
    if (clk_int) begin
      rise_ev = tick & ~sck_q;
      fall_ev = tick & sck_q;
    end else begin
      rise_ev = ext_rise;
      fall_ev = ext_fall;
    end
  end

  assign sck_int  = sck_q;
  assign ws_ext_s = ws_sync_q[SMSB];

endmodule

// File: rtl/i2s_port_txrx.sv
module i2s_port_txrx #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_int,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              ws_ext_s,
  input  logic [DATA_W-1:0] tx_left,
  input  logic [DATA_W-1:0] tx_right,
  input  logic              sd_in,
  output logic              ws_level,
  output logic              sd_bit,
  output logic [DATA_W-1:0] rx_left,
  output logic [DATA_W-1:0] rx_right,
  output logic              ws_rise_p,
  output logic              ws_fall_p
);

  localparam int unsigned POS_W = $clog2(2 * DATA_W);
  localparam int unsigned LOW_W = POS_W - 1;
  localparam logic [LOW_W-1:0] LOW_ONE = LOW_W'(1);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [DATA_W-1:0] tx_sh_q, tx_sh_d;
  logic [DATA_W-1:0] rx_sh_q, rx_sh_d;
  logic              tx_load, word_done;
  logic              ws_rise_d, ws_fall_d, ws_rise_q, ws_fall_q;
  logic [DATA_W-1:0] rx_q [2];

  // Bit position within the frame; the MSB is the word-select level.
  always_comb begin
    pos_d = pos_q;
    if (fall_ev) begin
      if (clk_int)                          pos_d = pos_q + 1'b1;
      else if (ws_ext_s != pos_q[POS_W-1])  pos_d = {ws_ext_s, {LOW_W{1'b0}}};
      else if (&pos_q[LOW_W-1:0])           pos_d = pos_q;
      else                                  pos_d = pos_q + 1'b1;
    end
  end

  // Load one bit after the word-select change, shift on every other fall.
  always_comb begin
    tx_load = fall_ev && (pos_d[LOW_W-1:0] == LOW_ONE);
    tx_sh_d = tx_sh_q;
    if (tx_load)      tx_sh_d = pos_d[POS_W-1] ? tx_right : tx_left;
    else if (fall_ev) tx_sh_d = {tx_sh_q[DATA_W-2:0], 1'b0};
  end

  always_comb begin
    rx_sh_d   = rise_ev ? {rx_sh_q[DATA_W-2:0], sd_in} : rx_sh_q;
    word_done = rise_ev && (pos_q[LOW_W-1:0] == '0);
    ws_rise_d = fall_ev & ~pos_q[POS_W-1] & pos_d[POS_W-1];
    ws_fall_d = fall_ev & pos_q[POS_W-1] & ~pos_d[POS_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      ws_rise_q <= 1'b0;
      ws_fall_q <= 1'b0;
    end else begin
      if (fall_ev) begin
        pos_q   <= pos_d;
        tx_sh_q <= tx_sh_d;
      end
      if (rise_ev) rx_sh_q <= rx_sh_d;
      ws_rise_q <= ws_rise_d;
      ws_fall_q <= ws_fall_d;
    end
  end

  // Receive latches: channel 0 (left) completes while word select is high,
  // channel 1 (right) completes while it is low.
  for (genvar ch = 0; ch < 2; ch++) begin : g_rx
    logic latch_en;
    assign latch_en = word_done && (pos_q[POS_W-1] == (ch == 0));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rx_q[ch] <= '0;
      else if (latch_en) rx_q[ch] <= rx_sh_d;
    end
  end

  assign ws_level  = pos_q[POS_W-1];
  assign sd_bit    = tx_sh_q[DATA_W-1];
  assign rx_left   = rx_q[0];
  assign rx_right  = rx_q[1];
  assign ws_rise_p = ws_rise_q;
  assign ws_fall_p = ws_fall_q;

endmodule

// File: rtl/i2s_port_irq.sv
module i2s_port_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_rise,
  input  logic en_fall,
  input  logic en_every,
  input  logic ws_rise_p,
  input  logic ws_fall_p,
  input  logic mode_wr,
  output logic irq,
  output logic irq_pending
);

  logic pend_q, pend_d;

  always_comb begin
    irq    = (ws_rise_p & (en_rise | en_every)) | (ws_fall_p & (en_fall | en_every));
    pend_d = pend_q;
    if (irq)          pend_d = 1'b1;
    else if (mode_wr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_pending = pend_q;

endmodule

// File: rtl/i2s_port.sv
module i2s_port
  import i2s_port_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DIV_RST = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic              sck_out,
  output logic              ws_out,
  output logic              sd_out,
  output logic              irq,
  output logic              irq_pending
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [DATA_W-1:0] tx_left_w, tx_right_w, rx_left_w, rx_right_w;
  logic [DIV_W-1:0]  div_w;
  mode_t             mode_w;
  logic              mode_wr_w, clk_int_w;
  logic              sck_int_w, rise_ev_w, fall_ev_w, ws_ext_w;
  logic              ws_level_w, sd_bit_w, ws_rise_w, ws_fall_w;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign clk_int_w = mode_w.clk_int;

  i2s_port_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_left(rx_left_w), .rx_right(rx_right_w),
    .tx_left(tx_left_w), .tx_right(tx_right_w),
    .div_n(div_w), .mode(mode_w), .mode_wr(mode_wr_w)
  );

  i2s_port_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_clkgen (
    .clk(clk), .rst_n(rst_n_i), .clk_int(clk_int_w), .div_n(div_w),
    .sck_ext(sck_in), .ws_ext(ws_in),
    .sck_int(sck_int_w), .rise_ev(rise_ev_w), .fall_ev(fall_ev_w), .ws_ext_s(ws_ext_w)
  );

  i2s_port_txrx #(.DATA_W(DATA_W)) u_txrx (
    .clk(clk), .rst_n(rst_n_i), .clk_int(clk_int_w),
    .rise_ev(rise_ev_w), .fall_ev(fall_ev_w), .ws_ext_s(ws_ext_w),
    .tx_left(tx_left_w), .tx_right(tx_right_w), .sd_in(sd_in),
    .ws_level(ws_level_w), .sd_bit(sd_bit_w),
    .rx_left(rx_left_w), .rx_right(rx_right_w),
    .ws_rise_p(ws_rise_w), .ws_fall_p(ws_fall_w)
  );

  i2s_port_irq u_irq (
    .clk(clk), .rst_n(rst_n_i),
    .en_rise(mode_w.irq_on_rise), .en_fall(mode_w.irq_on_fall), .en_every(mode_w.every_word),
    .ws_rise_p(ws_rise_w), .ws_fall_p(ws_fall_w), .mode_wr(mode_wr_w),
    .irq(irq), .irq_pending(irq_pending)
  );

  assign sck_out = clk_int_w & sck_int_w;
  assign ws_out  = clk_int_w & mode_w.strobe_en & ws_level_w;
  assign sd_out  = sd_bit_w;

endmodule

// File: rtl/i2s_port_chk.sv
module i2s_port_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              irq_pending,
  input logic              sck_out,
  input logic              ws_out,
  input logic              sd_out,
  input logic              mode_wr,
  input logic              clk_int,
  input logic              rise_ev,
  input logic [DATA_W-1:0] rx_left,
  input logic [DATA_W-1:0] rx_right
);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_pending_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq_pending);

  p_pending_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !irq) |=> !irq_pending);

  p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ws_out) && !$past(mode_wr)) |-> ($past(sck_out) && !sck_out));

  p_sd_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sd_out) && clk_int && $past(clk_int)) |-> ($past(sck_out) && !sck_out));

  p_rx_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rx_left) || !$stable(rx_right)) |-> $past(rise_ev));

endmodule

bind i2s_port i2s_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .irq(irq), .irq_pending(irq_pending),
  .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out),
  .mode_wr(mode_wr_w), .clk_int(clk_int_w), .rise_ev(rise_ev_w),
  .rx_left(rx_left_w), .rx_right(rx_right_w)
);

// File: tb/i2s_port_tb.sv
module i2s_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck_in = 1'b0, ws_in = 1'b0, ext_sd = 1'b0, loop_en = 1'b0;
  logic        sck_out, ws_out, sd_out, irq, irq_pending;
  logic        sd_in;

  assign sd_in = loop_en ? sd_out : ext_sd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out),
    .irq(irq), .irq_pending(irq_pending)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Serial stream monitor, sampled at the falling clock edge.
  logic [15:0] lw [64];
  logic [15:0] rw [64];
  int nl = 0, nr = 0, seg_len = 0, last_seg = 0, rise_cnt = 0;
  int irq_cnt = 0, irq_hi = 0, irq_wide = 0;
  logic [15:0] bits = '0;
  logic sck_prev = 1'b0, ws_last = 1'b0, armed = 1'b0, irq_prev = 1'b0;

  always @(negedge clk) begin
    if (sck_out && !sck_prev) begin
      bits = {bits[14:0], sd_out};
      rise_cnt++;
      if (ws_out != ws_last) begin
        if (armed) begin
          if (!ws_last) begin if (nl < 64) lw[nl] = bits; nl++; end
          else          begin if (nr < 64) rw[nr] = bits; nr++; end
          last_seg = seg_len;
        end
        armed   = 1'b1;
        seg_len = 1;
      end else begin
        seg_len++;
      end
      ws_last = ws_out;
    end
    sck_prev = sck_out;
    if (irq) begin
      irq_cnt++;
      if (ws_out)   irq_hi++;
      if (irq_prev) irq_wide++;
    end
    irq_prev = irq;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic mon_clear();
    @(posedge clk);
    armed = 1'b0; nl = 0; nr = 0;
    irq_cnt = 0; irq_hi = 0; irq_wide = 0;
  endtask

  task automatic wait_words(input int n);
    while (nl < n || nr < n) @(posedge clk);
  endtask

  task automatic meas(output int p);
    int r0;
    r0 = rise_cnt;
    while (rise_cnt == r0) @(posedge clk);
    p = 0;
    r0 = rise_cnt;
    while (rise_cnt == r0) begin @(posedge clk); p++; end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 irq_pending", irq_pending, 0);
    check("R1 sck_out", sck_out, 0);
    check("R1 ws_out", ws_out, 0);
    check("R1 sd_out", sd_out, 0);
    rd(4'h0, d); check("R1 rx left", d, 16'h0000);
    rd(4'h4, d); check("R1 rx right", d, 16'h0000);
  endtask

  task automatic t_reads();
    logic [15:0] d;
    rd(4'h8, d); check("R7 read 0x8", d, 16'hFFFF);
    rd(4'hC, d); check("R7 read 0xC", d, 16'hFFFF);
  endtask

  task automatic t_divider();
    int p;
    wr(4'hC, 16'h0001);
    meas(p); meas(p); check("R1 R2 default divider period", p, 40);
    wr(4'h8, 16'h0001);
    meas(p); meas(p); check("R2 N=1 period", p, 4);
    wr(4'h8, 16'h0004);
    meas(p); meas(p); check("R2 N=4 period", p, 10);
    wr(4'h8, 16'h0001);
  endtask

  task automatic t_transmit();
    logic [15:0] d;
    wr(4'h0, 16'hA5C3);
    wr(4'h4, 16'h1234);
    loop_en = 1'b1;
    wr(4'hC, 16'h0005);
    mon_clear();
    wait_words(3);
    check("R4 left word", lw[1], 16'hA5C3);
    check("R4 right word", rw[1], 16'h1234);
    check("R3 slot length", last_seg, 16);
    rd(4'h0, d); check("R6 rx left loopback", d, 16'hA5C3);
    rd(4'h4, d); check("R6 rx right loopback", d, 16'h1234);
  endtask

  task automatic t_midwrite();
    int n0;
    @(posedge clk);
    while (!(ws_last == 1'b0 && seg_len == 5 && armed)) @(posedge clk);
    n0 = nl;
    wr(4'h0, 16'h0F0F);
    while (nl < n0 + 2) @(posedge clk);
    check("R5 word in flight kept", lw[n0], 16'hA5C3);
    check("R5 new word next slot", lw[n0+1], 16'h0F0F);
    check("R5 right untouched", rw[nr-1], 16'h1234);
  endtask

  task automatic t_wsen();
    int bad, r0;
    wr(4'hC, 16'h0001);
    bad = 0;
    r0 = rise_cnt;
    repeat (256) begin @(negedge clk); if (ws_out) bad++; end
    check("R8 ws_out held low", bad, 0);
    check("R8 bit clock keeps running", rise_cnt - r0, 64);
  endtask

  task automatic t_irq();
    wr(4'hC, 16'h000D);
    mon_clear(); repeat (384) @(posedge clk);
    check("R9 rising-edge irq count", irq_cnt, 3);
    check("R9 rising-edge irq ws level", irq_hi, 3);
    check("R9 irq single cycle", irq_wide, 0);
    wr(4'hC, 16'h0015);
    mon_clear(); repeat (384) @(posedge clk);
    check("R9 falling-edge irq count", irq_cnt, 3);
    check("R9 falling-edge irq ws level", irq_hi, 0);
    wr(4'hC, 16'h0025);
    mon_clear(); repeat (384) @(posedge clk);
    check("R9 every-word irq count", irq_cnt, 6);
    check("R9 every-word single cycle", irq_wide, 0);
  endtask

  task automatic t_pending();
    int seen;
    @(negedge clk);
    check("R11 pending set", irq_pending, 1);
    @(posedge clk);
    while (!(seg_len == 5 && armed)) @(posedge clk);
    wr(4'hC, 16'h0005);
    check("R11 pending cleared by mode write", irq_pending, 0);
    mon_clear();
    seen = 0;
    repeat (256) begin @(negedge clk); if (irq_pending) seen++; end
    check("R10 no irq when disabled", irq_cnt, 0);
    check("R11 pending stays clear", seen, 0);
  endtask

  task automatic t_repeat();
    wr(4'h0, 16'h5A5A);
    wr(4'h4, 16'hC3C3);
    mon_clear();
    wait_words(4);
    check("R10 left repeats", lw[2], 16'h5A5A);
    check("R10 left repeats again", lw[3], 16'h5A5A);
    check("R10 right repeats", rw[3], 16'hC3C3);
    check("R10 no irq pulses", irq_cnt, 0);
  endtask

  int sck_hi_ext = 0;

  task automatic ext_bit(input logic ws, input logic b);
    @(negedge clk);
    sck_in = 1'b0; ws_in = ws; ext_sd = b;
    repeat (6) begin @(negedge clk); if (sck_out || ws_out) sck_hi_ext++; end
    sck_in = 1'b1;
    repeat (6) begin @(negedge clk); if (sck_out || ws_out) sck_hi_ext++; end
  endtask

  task automatic t_external();
    logic [15:0] d;
    logic [15:0] lv, rv;
    lv = 16'hC0DE; rv = 16'hBEEF;
    loop_en = 1'b0;
    wr(4'h8, 16'h00C8);
    wr(4'hC, 16'h0004);
    sck_hi_ext = 0;
    for (int f = 0; f < 3; f++) begin
      for (int j = 0; j < 32; j++) begin
        if (j == 0)       ext_bit(1'b0, rv[0]);
        else if (j <= 16) ext_bit(j == 16, lv[16-j]);
        else              ext_bit(1'b1, rv[32-j]);
      end
    end
    ext_bit(1'b0, rv[0]);
    ext_bit(1'b0, 1'b0);
    rd(4'h0, d); check("R12 external rx left", d, 16'hC0DE);
    rd(4'h4, d); check("R12 external rx right", d, 16'hBEEF);
    check("R12 outputs quiet in external mode", sck_hi_ext, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_reads();
    t_divider();
    t_transmit();
    t_midwrite();
    t_wsen();
    wr(4'hC, 16'h0005);
    t_irq();
    t_pending();
    t_repeat();
    t_external();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule